// File: doc/BRIEF.md
# Hint-Driven Region Prefetch Engine

This block watches the stream of load addresses that a processor sends to its data cache and turns them into block prefetch requests for the cache fill path. Software describes each data stream once, before a processing loop starts, by writing a few hint values per memory region: where the region begins, how long it is, how far ahead of the current load to fetch, how many bytes each request carries and which mode applies. From then on, ordinary cached loads drive the prefetching. The engine can therefore run bulk transfers well ahead of the computation, much like a double-buffered DMA scheme, but no transfer descriptors are needed.

Each region slot checks every observed load against its own window. It forms a line-aligned target that lies the prefetch distance ahead, clips the block to the region end, and drops requests for blocks it has already asked for. Each slot holds at most one request. A fixed-priority arbiter passes one request per accepted handshake to the memory side.

Top module: `pf_hint_engine`

## Requirements
- R1: A configuration write (`cfg_we` high) stores `cfg_wdata` into the slot chosen by `cfg_region`. The field is chosen by `cfg_field`: 0 base address, 1 region size in bytes, 2 block length in bytes (low `LEN_W` bits), 3 prefetch distance in bytes, 4 mode (low two bits). A region index with no slot has no effect.
- R2: A slot reacts to a sampled load at address A only when base ≤ A < base + size, its mode is 2'b01 (forward) or 2'b10 (one-shot), and its block length is non-zero. Mode 2'b00, mode 2'b11 and a zero block length produce no request.
- R3: The request start is A + distance aligned down to a multiple of `LINE_BYTES`. A start that falls below base is raised to base.
- R4: The request length is the smaller of the block length and (base + size − start). No request is made when start ≥ base + size, so no request ever reaches outside its region.
- R5: In forward mode, a request is made only when the start lies outside the byte range of the slot's last request. A load moving backwards to another block therefore re-arms the slot.
- R6: In one-shot mode, a request is made only when the start is at or above the slot's high-water mark, which is the end of its last request.
- R7: A slot holds at most one request. It keeps that request, with unchanged address and length, until `pf_ready` accepts it. Loads that arrive while a request is held are ignored by that slot.
- R8: When several slots hold requests, `pf_valid` presents the one with the lowest region index, and `pf_region` carries that index.
- R9: Writing any field of a slot cancels its held request and clears its last-request range and high-water mark to zero.
- R10: A load sampled at one rising edge that creates a request makes `pf_valid` high directly after that edge.
- R11: After reset all configuration is zero, every slot is disabled and `pf_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | RIDX_W | Slot index of the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | ADDR_W | Write data |
| ld_valid | input | 1 | A load address is present |
| ld_addr | input | ADDR_W | Observed load byte address |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | Memory side accepts the request |
| pf_addr | output | ADDR_W | Request start byte address |
| pf_len | output | LEN_W | Request length in bytes |
| pf_region | output | RIDX_W | Index of the slot that owns the request |

## Verification
The bench builds the engine with three slots, 32-bit addresses, 16-bit lengths and 32-byte lines. Three slots are enough to run one forward stream and one one-shot stream side by side with a linear load sweep, and still leave a third slot for the disabled encodings and for an overlapping window. That third slot sets up a two-way arbitration contest. The region end and base are chosen off the block grid in places, so that clipped lengths and starts raised to base both occur during the sweep.

// File: rtl/pf_hint_pkg.sv
package pf_hint_pkg;

   typedef enum logic [1:0] {
      PF_OFF  = 2'b00,
      PF_FWD  = 2'b01,
      PF_ONCE = 2'b10,
      PF_RSV  = 2'b11
   } pf_mode_e;

   localparam logic [2:0] FLD_BASE = 3'd0;
   localparam logic [2:0] FLD_SIZE = 3'd1;
   localparam logic [2:0] FLD_BLEN = 3'd2;
   localparam logic [2:0] FLD_DIST = 3'd3;
   localparam logic [2:0] FLD_MODE = 3'd4;

endpackage

// File: rtl/pf_region_slot.sv
module pf_region_slot
   import pf_hint_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LINE_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              acc,
   output logic              req_v,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_len
);

   localparam int EW = ADDR_W + 1;
   localparam logic [EW-1:0] LINE_MASK = ~(EW'(LINE_BYTES - 1));

   logic [ADDR_W-1:0] base_q, size_q, dist_q;
   logic [LEN_W-1:0]  blk_q;
   pf_mode_e          mode_q;
   logic [EW-1:0]     lo_q, hi_q;
   logic              pend_q;
   logic [ADDR_W-1:0] paddr_q;
   logic [LEN_W-1:0]  plen_q;

   logic [EW-1:0] end_w, tgt_w, aln_w, start_w, room_w, len_e;
   logic          enabled, in_win, fits, fresh, take;
   logic [LEN_W-1:0] len_w;

   always_comb begin
      end_w   = {1'b0, base_q} + {1'b0, size_q};
      tgt_w   = {1'b0, ld_addr} + {1'b0, dist_q};
      aln_w   = tgt_w & LINE_MASK;
      start_w = (aln_w < {1'b0, base_q}) ? {1'b0, base_q} : aln_w;
      room_w  = end_w - start_w;
      len_e   = (room_w < EW'(blk_q)) ? room_w : EW'(blk_q);
      len_w   = len_e[LEN_W-1:0];
      enabled = (mode_q == PF_FWD || mode_q == PF_ONCE) && (blk_q != '0);
      in_win  = ({1'b0, ld_addr} >= {1'b0, base_q}) && ({1'b0, ld_addr} < end_w);
      fits    = start_w < end_w;
      if (mode_q == PF_ONCE) fresh = start_w >= hi_q;
      else                   fresh = !((start_w >= lo_q) && (start_w < hi_q));
      take    = ld_valid && enabled && in_win && fits && fresh && !pend_q && !cfg_we;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         dist_q <= '0;
         blk_q  <= '0;
         mode_q <= PF_OFF;
      end else if (cfg_we) begin
         case (cfg_field)
            FLD_BASE: base_q <= cfg_wdata;
            FLD_SIZE: size_q <= cfg_wdata;
            FLD_BLEN: blk_q  <= cfg_wdata[LEN_W-1:0];
            FLD_DIST: dist_q <= cfg_wdata;
            FLD_MODE: mode_q <= pf_mode_e'(cfg_wdata[1:0]);
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         pend_q  <= 1'b0;
         paddr_q <= '0;
         plen_q  <= '0;
      end else if (cfg_we) begin
         lo_q   <= '0;
         hi_q   <= '0;
         pend_q <= 1'b0;
      end else if (take) begin
         lo_q    <= start_w;
         hi_q    <= start_w + len_e;
         pend_q  <= 1'b1;
         paddr_q <= start_w[ADDR_W-1:0];
         plen_q  <= len_w;
      end else if (acc) begin
         pend_q <= 1'b0;
      end
   end

   assign req_v    = pend_q;
   assign req_addr = paddr_q;
   assign req_len  = plen_q;

   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_v && !acc && !cfg_we) |=> (req_v && $stable(req_addr) && $stable(req_len))); // R7
   AST_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      req_v |-> (({1'b0, req_addr} >= {1'b0, base_q}) && (({1'b0, req_addr} + EW'(req_len)) <= end_w))); // R4
   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      req_v |-> ((req_len != '0) && (req_len <= blk_q))); // R4
   AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !req_v); // R9
   AST_ONCE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) == PF_ONCE && mode_q == PF_ONCE && !$past(cfg_we)) |-> (hi_q >= $past(hi_q))); // R6

endmodule

// File: rtl/pf_prio_arb.sv
module pf_prio_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   logic [N:0] lower;

   assign lower[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_stage
      assign gnt[i]     = req[i] & ~lower[i];
      assign lower[i+1] = lower[i] | req[i];
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R8
   AST_GNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> ($countones(gnt) == 1)); // R8

endmodule

// File: rtl/pf_hint_engine.sv
module pf_hint_engine
   import pf_hint_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int N_REGIONS  = 4,
   parameter int LEN_W      = 16,
   parameter int LINE_BYTES = 32,
   localparam int RIDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [RIDX_W-1:0] cfg_region,
   input  logic [2:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr,
   output logic [LEN_W-1:0]  pf_len,
   output logic [RIDX_W-1:0] pf_region
);

   initial begin
      AST_PARAM_REGIONS: assert (N_REGIONS >= 1 && N_REGIONS <= 64)
         else $error("N_REGIONS out of range"); // R8
      AST_PARAM_LINE: assert (LINE_BYTES >= 1 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("LINE_BYTES must be a power of two"); // R3
      AST_PARAM_LEN: assert (LEN_W >= 1 && LEN_W <= ADDR_W)
         else $error("LEN_W must not exceed ADDR_W"); // R4
   end

   logic [N_REGIONS-1:0] req_v, gnt;
   logic [ADDR_W-1:0]    r_addr [N_REGIONS];
   logic [LEN_W-1:0]     r_len  [N_REGIONS];

   for (genvar i = 0; i < N_REGIONS; i++) begin : g_slot
      logic sel_w;
      assign sel_w = cfg_we && (cfg_region == RIDX_W'(i));

      pf_region_slot #(
         .ADDR_W    (ADDR_W),
         .LEN_W     (LEN_W),
         .LINE_BYTES(LINE_BYTES)
      ) i_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (sel_w),
         .cfg_field(cfg_field),
         .cfg_wdata(cfg_wdata),
         .ld_valid (ld_valid),
         .ld_addr  (ld_addr),
         .acc      (gnt[i] && pf_ready),
         .req_v    (req_v[i]),
         .req_addr (r_addr[i]),
         .req_len  (r_len[i])
      );
   end

   pf_prio_arb #(.N(N_REGIONS)) i_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_v),
      .gnt  (gnt)
   );

   always_comb begin
      pf_addr   = '0;
      pf_len    = '0;
      pf_region = '0;
      for (int i = 0; i < N_REGIONS; i++) begin
         if (gnt[i]) begin
            pf_addr   = r_addr[i];
            pf_len    = r_len[i];
            pf_region = RIDX_W'(i);
         end
      end
   end

   assign pf_valid = |req_v;

   AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready && !cfg_we) |=> (pf_valid && pf_region <= $past(pf_region))); // R8
   AST_NO_LOAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!pf_valid && !ld_valid) |=> !pf_valid); // R10

endmodule

// File: tb/test_pf_hint_engine.sv
module test_pf_hint_engine;

   localparam int AW = 32;
   localparam int NR = 3;
   localparam int LW = 16;
   localparam int RW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [RW-1:0] cfg_region = '0;
   logic [2:0]    cfg_field = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          ld_valid = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic          pf_valid;
   logic          pf_ready = 1'b1;
   logic [AW-1:0] pf_addr;
   logic [LW-1:0] pf_len;
   logic [RW-1:0] pf_region;

   always #10 clk = ~clk;

   pf_hint_engine #(.ADDR_W(AW), .N_REGIONS(NR), .LEN_W(LW), .LINE_BYTES(32)) i_pf_hint_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .ld_valid(ld_valid),
      .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
      .pf_addr(pf_addr), .pf_len(pf_len), .pf_region(pf_region)
   );

   typedef struct packed {
      logic [AW-1:0] a;
      logic [LW-1:0] l;
      logic [RW-1:0] r;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_err = 0;

   logic [32:0] mb [NR], ms [NR], md [NR], mlo [NR], mhi [NR];
   logic [LW-1:0] mblk [NR];
   logic [1:0]    mmode [NR];

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic predict(input logic [AW-1:0] a, output int n);
      n = 0;
      for (int r = 0; r < NR; r++) begin
         logic [32:0] e_end, t, s, len33;
         logic fresh;
         e_end = mb[r] + ms[r];
         if (!((mmode[r] == 2'b01 || mmode[r] == 2'b10) && mblk[r] != '0)) continue;
         if (!({1'b0, a} >= mb[r] && {1'b0, a} < e_end)) continue;
         t = {1'b0, a} + md[r];
         s = t & ~33'h1F;
         if (s < mb[r]) s = mb[r];
         if (s >= e_end) continue;
         if (mmode[r] == 2'b01) fresh = !(s >= mlo[r] && s < mhi[r]);
         else                   fresh = (s >= mhi[r]);
         if (!fresh) continue;
         len33 = e_end - s;
         if (len33 > {17'd0, mblk[r]}) len33 = {17'd0, mblk[r]};
         mlo[r] = s;
         mhi[r] = s + len33;
         q.push_back('{a: s[AW-1:0], l: len33[LW-1:0], r: RW'(r)});
         n++;
      end
   endtask

   // R1: field codes 0 base, 1 size, 2 block length, 3 distance, 4 mode
   task automatic wr(input int r, input int f, input logic [AW-1:0] d);
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_region = RW'(r); cfg_field = 3'(f); cfg_wdata = d;
      @(posedge clk); #2;
      cfg_we = 1'b0;
      if (r < NR) begin
         case (f)
            0: mb[r] = {1'b0, d};
            1: ms[r] = {1'b0, d};
            2: mblk[r] = d[LW-1:0];
            3: md[r] = {1'b0, d};
            4: mmode[r] = d[1:0];
            default: ;
         endcase
         mlo[r] = '0;
         mhi[r] = '0;
      end
   endtask

   task automatic cfg_slot(input int r, input logic [AW-1:0] b, input logic [AW-1:0] s,
                           input logic [AW-1:0] bl, input logic [AW-1:0] d, input logic [AW-1:0] m);
      wr(r, 0, b); wr(r, 1, s); wr(r, 2, bl); wr(r, 3, d); wr(r, 4, m);
   endtask

   task automatic raw_load(input logic [AW-1:0] a);
      @(posedge clk); #2;
      ld_valid = 1'b1; ld_addr = a;
      @(posedge clk); #2;
      ld_valid = 1'b0;
   endtask

   // model-tracked load; with ready high, checks R10 timing and R2 silence
   task automatic do_load(input logic [AW-1:0] a, input bit drain);
      int n;
      predict(a, n);
      raw_load(a);
      if (drain) begin
         @(negedge clk);
         chk(pf_valid == (n > 0), (n > 0) ? "R10" : "R2", "pf_valid after load", pf_valid, (n > 0));
         repeat (n + 2) @(posedge clk);
      end
   endtask

   // monitor: pops the scoreboard on every accepted request
   always @(negedge clk) begin
      if (rst_n && pf_valid && pf_ready) begin
         if (q.size() == 0) begin
            chk(1'b0, "R7", "unexpected request", pf_addr, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(pf_addr == e.a, "R3", "request address", pf_addr, e.a);
            chk(pf_len == e.l, "R4", "request length", pf_len, e.l);
            chk(pf_region == e.r, "R8", "request region", pf_region, e.r);
            if (pf_region < RW'(NR))
               chk(({1'b0, pf_addr} >= mb[pf_region]) &&
                   (({1'b0, pf_addr} + 33'(pf_len)) <= mb[pf_region] + ms[pf_region]),
                   "R4", "request inside region", pf_addr, mb[pf_region]);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int r = 0; r < NR; r++) begin
         mb[r] = '0; ms[r] = '0; md[r] = '0; mlo[r] = '0; mhi[r] = '0;
         mblk[r] = '0; mmode[r] = '0;
      end
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(pf_valid == 1'b0, "R11", "pf_valid after reset", pf_valid, 0);

      // R11: slots are disabled after reset
      do_load(32'h0000_0000, 1'b1);

      cfg_slot(0, 32'h1000, 32'h400, 64, 128, 1);  // forward
      cfg_slot(1, 32'h2010, 32'h1E8, 96, 8, 2);    // one-shot, unaligned end
      cfg_slot(2, 32'h3000, 32'h100, 0, 0, 1);     // zero block length
      wr(3, 0, 32'h1000);                          // R1: no such slot

      // linear sweep through both active regions (R3, R4, R5, R6)
      for (int a = 32'h0F00; a < 32'h2300; a += 16)
         do_load(AW'(a), 1'b1);

      // R2: zero block length, then reserved mode, then disabled mode
      do_load(32'h3000, 1'b1);
      do_load(32'h3040, 1'b1);
      wr(2, 2, 32);
      wr(2, 4, 3);
      do_load(32'h3000, 1'b1);
      wr(2, 4, 0);
      do_load(32'h3020, 1'b1);

      // R5: forward mode re-arms on a backward jump
      do_load(32'h1000, 1'b1);
      // R6: one-shot below high-water mark stays silent
      do_load(32'h2010, 1'b1);

      // R8: overlapping windows, both slots hold a request
      cfg_slot(2, 32'h1000, 32'h100, 32, 0, 1);
      wr(0, 3, 128);
      pf_ready = 1'b0;
      do_load(32'h1040, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pf_valid == 1'b1, "R7", "request held without ready", pf_valid, 1);
      chk(pf_region == 2'd0, "R8", "lowest index presented first", pf_region, 0);
      chk(pf_addr == 32'h10C0, "R7", "held address stable", pf_addr, 32'h10C0);
      @(posedge clk); #2 pf_ready = 1'b1;
      repeat (4) @(posedge clk);
      chk(q.size() == 0, "R8", "both requests drained", q.size(), 0);

      // R7: a load arriving while a request is held is ignored
      wr(2, 4, 0);
      pf_ready = 1'b0;
      do_load(32'h1000, 1'b0);
      raw_load(32'h1200);
      @(posedge clk); #2 pf_ready = 1'b1;
      repeat (4) @(posedge clk);
      chk(q.size() == 0, "R7", "single request after drop", q.size(), 0);

      // R9: a write cancels the held request and clears the pointer
      do_load(32'h1100, 1'b1);
      pf_ready = 1'b0;
      raw_load(32'h1000);
      @(negedge clk);
      chk(pf_valid == 1'b1, "R9", "request pending before write", pf_valid, 1);
      wr(0, 3, 128);
      @(negedge clk);
      chk(pf_valid == 1'b0, "R9", "request cancelled by write", pf_valid, 0);
      @(posedge clk); #2 pf_ready = 1'b1;
      repeat (3) @(posedge clk);
      do_load(32'h1100, 1'b1);
      do_load(32'h1100, 1'b1);

      repeat (4) @(posedge clk);
      chk(q.size() == 0, "R7", "scoreboard empty at end", q.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule